// File: doc/BRIEF.md
# Frame-Transfer Sensor Readout Sequencer

This block produces the gate-clock levels and converter strobes that drain a frame-transfer image sensor. The sensor has two halves. The image half is exposed to light. The storage half is masked and holds the previous frame. Each half is `N_COLS` columns wide, and each column is `N_ROWS` pixels tall. A serial register along one edge of the storage half feeds an external A/D converter.

Each of the three areas (image, storage, serial) has its own three-phase clock. At rest the centre gate of every pixel is high and its two neighbours are low. Charge moves one pixel when the high level rotates through the three gates in turn.

After `start_i`, the block drains the storage half one column at a time. It first shifts every storage column one pixel toward the serial register. It then clocks that register out pixel by pixel, and raises `adc_start_o` once for each pixel. It waits for `adc_done_i` before it moves the next pixel. When every storage pixel has been converted, a fast burst moves the image half into the storage half. The block then pulses `frame_done_o` and starts draining the new frame without further input. The image half is never clocked outside the burst, so exposure is never interrupted.

Top module: `ft_readout_seq`

## Requirements
- R1: While `rst_ni` is low, and in the idle state that follows reset until `start_i` is seen high at a clock edge, every phase group reads 3'b010 and `adc_start_o` and `frame_done_o` stay low. In a phase group, bit 1 is the centre gate, bit 2 is the next gate and bit 0 is the third gate.
- R2: Exactly one bit of each phase group is high at all times. Each step moves the high level from bit 1 to bit 2, from bit 2 to bit 0, and from bit 0 back to bit 1. Three steps move charge by one pixel, and a group is back at 3'b010 whenever `adc_start_o` is high.
- R3: The image phases change only during the fast transfer burst. Outside it they hold 3'b010.
- R4: A storage column shift is three storage-phase steps spaced `SLOW_STEP_CYC` cycles apart. It is followed directly by the first serial pixel. The first `adc_start_o` of a column comes 3*`SLOW_STEP_CYC` + 3*`SER_STEP_CYC` cycles after the clock edge that starts the column: the edge that samples `start_i`, the edge that accepts the last `adc_done_i` of the previous column, or the edge that ends the fast burst.
- R5: Each serial pixel is three serial-phase steps spaced `SER_STEP_CYC` cycles apart, followed by a one-cycle `adc_start_o`. The storage and serial phases then hold until `adc_done_i` is sampled high. The next `adc_start_o` of the same column comes 3*`SER_STEP_CYC` cycles after that edge. A column yields `N_ROWS` conversions before the next storage shift.
- R6: `adc_done_i` has no effect unless a conversion is outstanding, that is, from the cycle in which `adc_start_o` is high until `adc_done_i` is accepted.
- R7: The edge that accepts the `N_COLS`*`N_ROWS`-th conversion of a frame starts the fast burst. In the burst, the image and storage phases step together every `FAST_STEP_CYC` cycles, three steps per column, for `N_COLS` columns. `frame_done_o` rises 3*`N_COLS`*`FAST_STEP_CYC` cycles after that edge, and the image phases have stepped exactly 3*`N_COLS` times in the frame.
- R8: `frame_done_o` is a one-cycle pulse. The next frame's storage drain follows it at once, with no new `start_i`.
- R9: `start_i` has no effect once the sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the first readout cycle from idle |
| adc_done_i | input | 1 | Converter has finished the current pixel |
| img_ph_o | output | 3 | Image-half three-phase gate levels |
| sto_ph_o | output | 3 | Storage-half three-phase gate levels |
| ser_ph_o | output | 3 | Serial-register three-phase gate levels |
| adc_start_o | output | 1 | One-cycle request to convert the pixel at the register output |
| frame_done_o | output | 1 | One-cycle pulse when the image half has reached storage |

## Verification
The assertions assume that `adc_done_i` answers only conversions that are outstanding. A stray `adc_done_i` at any other time must be harmless, and the assertions tie the hold and strobe behaviour to the internal state, not to the handshake's history. The stimulus answers each `adc_start_o` after a random delay of zero to four cycles. Between conversions and during the burst, it fires random spurious `adc_done_i` and `start_i` pulses. It never drives a spurious pulse into a cycle in which a conversion is outstanding. Any reaction to these pulses would shift the exact strobe spacing that the bench measures.

// File: rtl/ft_seq_pkg.sv
`timescale 1ns/1ps
package ft_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_STORE, ST_SERIAL, ST_WAIT, ST_FAST} seq_state_e;

  localparam logic [2:0] PH_REST = 3'b010;
  localparam int unsigned STEPS_PER_PIX = 3;

  // high gate walks centre -> next -> third -> centre
  function automatic logic [2:0] ph_next(input logic [2:0] p);
    return {p[1:0], p[2]};
  endfunction
endpackage

// File: rtl/ft_phase_rot.sv
`timescale 1ns/1ps
module ft_phase_rot
  import ft_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  output logic [2:0] ph_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_o <= PH_REST;
    else if (step_i) ph_o <= ph_next(ph_o);
  end

  // R2
  ph_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ph_o) == 1);
endmodule

// File: rtl/ft_step_timer.sv
`timescale 1ns/1ps
module ft_step_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [TW-1:0] period_i,
  output logic          tick_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] last;

  assign last   = period_i - TW'(1);
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= (cnt_q == last) ? '0 : cnt_q + TW'(1);
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= last);
endmodule

// File: rtl/ft_readout_seq.sv
`timescale 1ns/1ps
module ft_readout_seq
  import ft_seq_pkg::*;
#(
  parameter int N_COLS        = 288,
  parameter int N_ROWS        = 16,
  parameter int SLOW_STEP_CYC = 50,
  parameter int SER_STEP_CYC  = 4,
  parameter int FAST_STEP_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       adc_done_i,
  output logic [2:0] img_ph_o,
  output logic [2:0] sto_ph_o,
  output logic [2:0] ser_ph_o,
  output logic       adc_start_o,
  output logic       frame_done_o
);
  localparam int CW = (N_COLS > 1) ? $clog2(N_COLS) : 1;
  localparam int RW = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;
  localparam int MAXP = (SLOW_STEP_CYC > SER_STEP_CYC) ?
                        ((SLOW_STEP_CYC > FAST_STEP_CYC) ? SLOW_STEP_CYC : FAST_STEP_CYC) :
                        ((SER_STEP_CYC > FAST_STEP_CYC) ? SER_STEP_CYC : FAST_STEP_CYC);
  localparam int TW = $clog2(MAXP + 1);
  localparam logic [CW-1:0] COL_LAST = CW'(N_COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(N_ROWS - 1);
  localparam logic [1:0]    SUB_LAST = 2'(STEPS_PER_PIX - 1);

  seq_state_e state_q, state_d;
  logic [1:0]    sub_q, sub_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;
  logic          adc_start_d, frame_done_d;
  logic          img_step, sto_step, ser_step;
  logic          run, clr, tick;
  logic [TW-1:0] period;

  always_comb begin
    case (state_q)
      ST_SERIAL: period = TW'(SER_STEP_CYC);
      ST_FAST:   period = TW'(FAST_STEP_CYC);
      default:   period = TW'(SLOW_STEP_CYC);
    endcase
  end

  assign run = (state_q == ST_STORE) || (state_q == ST_SERIAL) || (state_q == ST_FAST);
  assign clr = (state_d != state_q);

  ft_step_timer #(.TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .run_i    (run),
    .period_i (period),
    .tick_o   (tick)
  );

  always_comb begin
    state_d      = state_q;
    sub_d        = sub_q;
    row_d        = row_q;
    col_d        = col_q;
    img_step     = 1'b0;
    sto_step     = 1'b0;
    ser_step     = 1'b0;
    adc_start_d  = 1'b0;
    frame_done_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_STORE;
          sub_d   = '0;
          row_d   = '0;
          col_d   = '0;
        end
      end
      ST_STORE: begin
        if (tick) begin
          sto_step = 1'b1;
          if (sub_q == SUB_LAST) begin
            sub_d   = '0;
            state_d = ST_SERIAL;
          end else sub_d = sub_q + 2'd1;
        end
      end
      ST_SERIAL: begin
        if (tick) begin
          ser_step = 1'b1;
          if (sub_q == SUB_LAST) begin
            sub_d       = '0;
            state_d     = ST_WAIT;
            adc_start_d = 1'b1;
          end else sub_d = sub_q + 2'd1;
        end
      end
      ST_WAIT: begin
        if (adc_done_i) begin
          if (row_q == ROW_LAST) begin
            row_d = '0;
            if (col_q == COL_LAST) begin
              col_d   = '0;
              state_d = ST_FAST;
            end else begin
              col_d   = col_q + CW'(1);
              state_d = ST_STORE;
            end
          end else begin
            row_d   = row_q + RW'(1);
            state_d = ST_SERIAL;
          end
        end
      end
      ST_FAST: begin
        if (tick) begin
          img_step = 1'b1;
          sto_step = 1'b1;
          if (sub_q == SUB_LAST) begin
            sub_d = '0;
            if (col_q == COL_LAST) begin
              col_d        = '0;
              state_d      = ST_STORE;
              frame_done_d = 1'b1;
            end else col_d = col_q + CW'(1);
          end else sub_d = sub_q + 2'd1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sub_q        <= '0;
      row_q        <= '0;
      col_q        <= '0;
      adc_start_o  <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      sub_q        <= sub_d;
      row_q        <= row_d;
      col_q        <= col_d;
      adc_start_o  <= adc_start_d;
      frame_done_o <= frame_done_d;
    end
  end

  ft_phase_rot u_img (.clk_i(clk_i), .rst_ni(rst_ni), .step_i(img_step), .ph_o(img_ph_o));
  ft_phase_rot u_sto (.clk_i(clk_i), .rst_ni(rst_ni), .step_i(sto_step), .ph_o(sto_ph_o));
  ft_phase_rot u_ser (.clk_i(clk_i), .rst_ni(rst_ni), .step_i(ser_step), .ph_o(ser_ph_o));

  // R1
  idle_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (img_ph_o == PH_REST && sto_ph_o == PH_REST &&
                              ser_ph_o == PH_REST && !adc_start_o && !frame_done_o));
  // R3
  img_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_FAST) |=> $stable(img_ph_o));
  // R4
  sto_hold_serial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SERIAL) |=> $stable(sto_ph_o));
  // R5
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> ($stable(sto_ph_o) && $stable(ser_ph_o)));
  // R5
  adc_start_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (state_q == ST_WAIT && ser_ph_o == PH_REST && sto_ph_o == PH_REST));
  // R8
  frame_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (state_q == ST_STORE && img_ph_o == PH_REST) ##1 !frame_done_o);
endmodule

// File: tb/sim_ft_readout_seq.sv
`timescale 1ns/1ps
module sim_ft_readout_seq;
  localparam int C  = 4;
  localparam int R  = 3;
  localparam int SL = 3;
  localparam int SE = 2;
  localparam int FA = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, adc_done_i = 1'b0;
  logic [2:0] img_ph_o, sto_ph_o, ser_ph_o;
  logic adc_start_o, frame_done_o;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int ref_edge, img_chg;
  bit spur_en = 1'b0;
  logic [2:0] img_p, sto_p, ser_p, sto_h, ser_h;

  ft_readout_seq #(.N_COLS(C), .N_ROWS(R), .SLOW_STEP_CYC(SL),
                   .SER_STEP_CYC(SE), .FAST_STEP_CYC(FA)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .adc_done_i(adc_done_i),
    .img_ph_o(img_ph_o), .sto_ph_o(sto_ph_o), .ser_ph_o(ser_ph_o),
    .adc_start_o(adc_start_o), .frame_done_o(frame_done_o));

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [2:0] rot(input logic [2:0] p);
    return {p[1:0], p[2]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic rot_chk(input logic [2:0] cur, inout logic [2:0] prev);
    if (cur != prev) check(cur == rot(prev), "R2 rotation", int'(cur), int'(rot(prev)));
    prev = cur;
  endtask

  task automatic tick();
    @(negedge clk_i);
    if (img_ph_o != img_p) img_chg++;
    rot_chk(img_ph_o, img_p);
    rot_chk(sto_ph_o, sto_p);
    rot_chk(ser_ph_o, ser_p);
    if (spur_en && !adc_start_o) begin
      adc_done_i = ($urandom % 4) == 0;   // R6 stray handshakes
      start_i    = ($urandom % 5) == 0;   // R9 stray starts
    end else begin
      adc_done_i = 1'b0;
      start_i    = 1'b0;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    img_p = 3'b010; sto_p = 3'b010; ser_p = 3'b010;
    repeat (3) tick();
    check(img_ph_o == 3'b010 && sto_ph_o == 3'b010 && ser_ph_o == 3'b010, "R1 in reset",
          int'(sto_ph_o), 2);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      check(img_ph_o == 3'b010 && sto_ph_o == 3'b010 && ser_ph_o == 3'b010 &&
            !adc_start_o && !frame_done_o, "R1 idle", int'({adc_start_o, frame_done_o}), 0);
    end
    start_i  = 1'b1;
    ref_edge = cyc + 1;
    for (int f = 0; f < 3; f++) begin
      img_chg = 0;
      for (int c = 0; c < C; c++) begin
        for (int r = 0; r < R; r++) begin
          spur_en = 1'b1;
          do tick(); while (!adc_start_o);
          spur_en = 1'b0;
          if (r == 0)
            check(cyc - ref_edge == 3*SL + 3*SE, "R4 column start spacing", cyc - ref_edge, 3*SL + 3*SE);
          else
            check(cyc - ref_edge == 3*SE, "R5 pixel spacing", cyc - ref_edge, 3*SE);
          check(sto_ph_o == 3'b010 && ser_ph_o == 3'b010, "R2 rest at convert",
                int'({sto_ph_o, ser_ph_o}), 8'o22);
          check(img_ph_o == 3'b010, "R3 image held", int'(img_ph_o), 2);
          sto_h = sto_ph_o; ser_h = ser_ph_o;
          for (int k = $urandom % 5; k > 0; k--) begin
            tick();
            check(!adc_start_o && sto_ph_o == sto_h && ser_ph_o == ser_h, "R5 hold while waiting",
                  int'({adc_start_o, sto_ph_o, ser_ph_o}), int'({1'b0, sto_h, ser_h}));
          end
          adc_done_i = 1'b1;
          ref_edge   = cyc + 1;
        end
      end
      spur_en = 1'b1;
      do tick(); while (!frame_done_o);
      check(cyc - ref_edge == 3*C*FA, "R7 burst length", cyc - ref_edge, 3*C*FA);
      check(img_chg == 3*C, "R7 image steps", img_chg, 3*C);
      ref_edge = cyc;
      spur_en  = 1'b0;
      tick();
      check(!frame_done_o, "R8 single pulse", int'(frame_done_o), 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule